// File: doc/BRIEF.md
# SONET B1 Parity Error Counter

This block watches a byte-wide STS-1 receive stream and checks its section parity. It works out a bit-interleaved even parity (BIP-8) over every byte of each frame. A frame runs from the byte marked by the frame-start pulse up to the byte before the next pulse. The B1 byte is the first byte of a frame and carries the parity of the frame before it. The block compares that byte with the value it computed for the previous frame and adds the mismatches to a saturating error counter.

A mode input picks how mismatches are weighed. One mode adds each disagreeing bit. The other adds one for each frame whose B1 byte is wrong in any bit. A host reads the count one byte at a time through a small register window, and the read clears the count. A read of the top byte freezes the whole count in a snapshot, so the lower bytes read afterwards belong to the same value. Errors that arrive while the count is being cleared go into the new count and are not lost.

Top module: `b1_err_counter`

## Requirements
- R1: The parity of a frame is the XOR of every byte accepted with `valid_i` high, from the byte with `sof_i` high (the B1 byte itself) through the last byte before the next `sof_i`. Cycles with `valid_i` low do not change it, and bytes before the first `sof_i` after reset are ignored.
- R2: The B1 byte of each frame is compared with the parity of the frame before it. The first frame after reset is never compared, so its B1 byte adds nothing.
- R3: With `per_frame_i` = 0, each compared frame adds the number of bit positions where B1 and the expected parity differ (0 to 8).
- R4: With `per_frame_i` = 1, each compared frame whose B1 differs in at least one bit adds exactly 1, and a frame with a correct B1 adds 0.
- R5: A read is a cycle with `rd_en_i` high. At that clock edge `rd_data_o` loads the byte that `rd_addr_i` selects and keeps it until the next read. Address 0 selects count bits [31:24], 1 selects [23:16], 2 selects [15:8] and 3 selects [7:0], so the most significant byte sits at the lowest address.
- R6: A read of address 0 copies the live count into a snapshot and clears the live count at the same edge. Reads of addresses 1 to 3 return bytes of that snapshot, even if errors arrive in between.
- R7: An increment that lands on the same edge as an address-0 read goes into the freshly cleared count and is left out of the snapshot.
- R8: The count stops at all ones (0xFFFFFFFF) and never wraps.
- R9: After reset the count, the snapshot and `rd_data_o` are zero.

Each counted frame changes the count one clock edge after the edge that accepts its `sof_i` byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | `data_i` holds a stream byte this cycle |
| sof_i | input | 1 | The current byte is the first (B1) byte of a frame |
| data_i | input | 8 | Received stream byte |
| per_frame_i | input | 1 | Counting mode: 0 adds erred bits, 1 adds erred frames |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 2 | Byte address of the read, 0 being the most significant |
| rd_data_o | output | 8 | Byte returned by the last read |

## Verification
The bench drives every one of the 256 B1 error patterns against the true parity. It does this once in bit mode, where the sum of population counts exposes a wrong weight or a missing bit lane, and once in frame mode, where only the count of nonzero patterns may show. Each frame carries payload bytes that vary with the frame, plus an idle cycle with garbage on the data lines, so the check also shows whether payload bytes enter the parity and whether invalid cycles stay out of it. Other patterns cover the rest. A bad first B1 byte must not be counted. A frame check is timed onto the same edge as a top-byte read, which separates snapshot contents from carried-over errors. An errored frame arrives between snapshot reads to confirm the snapshot stays frozen. A narrower 16-bit instance shows the byte order and is driven past saturation.

// File: rtl/b1_pkg.sv
`timescale 1ns/1ps
package b1_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned INC_W  = $clog2(BYTE_W + 1);

  typedef enum logic {
    CNT_PER_BIT   = 1'b0,
    CNT_PER_FRAME = 1'b1
  } cnt_mode_e;

  typedef struct packed {
    logic              vld;
    logic [BYTE_W-1:0] mask;
  } b1_chk_t;
endpackage

// File: rtl/b1_bip8_calc.sv
`timescale 1ns/1ps
module b1_bip8_calc
  import b1_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [BYTE_W-1:0] data_i,
  output b1_chk_t           chk_o
);
  logic [BYTE_W-1:0] acc_q;
  logic              in_frame_q;
  b1_chk_t           chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      in_frame_q <= 1'b0;
      chk_q      <= '0;
    end else begin
      chk_q.vld <= 1'b0;
      if (valid_i) begin
        if (sof_i) begin
          // B1 of this frame against parity of the frame just ended
          chk_q.vld  <= in_frame_q;
          chk_q.mask <= data_i ^ acc_q;
          acc_q      <= data_i;
          in_frame_q <= 1'b1;
        end else if (in_frame_q) begin
          acc_q <= acc_q ^ data_i;
        end
      end
    end
  end

  assign chk_o = chk_q;

  a_r2_check_after_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_o.vld |-> $past(valid_i && sof_i));

  a_r2_no_first_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i && sof_i) && !$past(in_frame_q)) |-> !chk_o.vld);

  a_r1_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(acc_q));
endmodule

// File: rtl/b1_err_weight.sv
`timescale 1ns/1ps
module b1_err_weight
  import b1_pkg::*;
(
  input  b1_chk_t          chk_i,
  input  logic             per_frame_i,
  output logic             add_vld_o,
  output logic [INC_W-1:0] add_o
);
  cnt_mode_e        mode;
  logic [INC_W-1:0] ones;

  assign mode = cnt_mode_e'(per_frame_i);

  always_comb begin
    ones = '0;
    for (int i = 0; i < int'(BYTE_W); i++) ones = ones + INC_W'(chk_i.mask[i]);
  end

  always_comb begin
    unique case (mode)
      CNT_PER_FRAME: add_o = INC_W'(|chk_i.mask);
      default:       add_o = ones;
    endcase
  end

  assign add_vld_o = chk_i.vld;

  always_comb begin
    if (chk_i.vld && mode == CNT_PER_FRAME)
      a_r4_unit_step: assert (add_o <= INC_W'(1));
  end
endmodule

// File: rtl/b1_err_accum.sv
`timescale 1ns/1ps
module b1_err_accum
  import b1_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_vld_i,
  input  logic [INC_W-1:0] add_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, base, inc;
  logic [CNT_W:0]   sum;

  assign base = clr_i ? '0 : cnt_q;
  assign inc  = add_vld_i ? {{(CNT_W-INC_W){1'b0}}, add_i} : '0;
  assign sum  = {1'b0, base} + {1'b0, inc};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (sum[CNT_W]) cnt_q <= '1;
    else              cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> cnt_q >= $past(cnt_q));

  a_r3_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> (cnt_q - $past(cnt_q)) <= CNT_W'(BYTE_W));

  a_r7_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> cnt_q <= CNT_W'(BYTE_W));
endmodule

// File: rtl/b1_host_regs.sv
`timescale 1ns/1ps
module b1_host_regs
  import b1_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned NUM_B  = CNT_W / BYTE_W,
  localparam int unsigned ADDR_W = (NUM_B > 1) ? $clog2(NUM_B) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              clr_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [CNT_W-1:0]  snap_q;
  logic [BYTE_W-1:0] rd_q;
  logic [BYTE_W-1:0] snap_by_addr [NUM_B];
  logic              is_top;

  // address 0 = most significant byte
  for (genvar g = 0; g < int'(NUM_B); g++) begin : g_bytes
    assign snap_by_addr[g] = snap_q[CNT_W-1-g*BYTE_W -: BYTE_W];
  end

  assign is_top = (rd_addr_i == '0);
  assign clr_o  = rd_en_i && is_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      rd_q   <= '0;
    end else if (rd_en_i) begin
      if (is_top) begin
        snap_q <= cnt_i;
        rd_q   <= cnt_i[CNT_W-1 -: BYTE_W];
      end else begin
        rd_q <= snap_by_addr[rd_addr_i];
      end
    end
  end

  assign rd_data_o = rd_q;

  a_r6_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && rd_addr_i == '0) |-> snap_q == $past(cnt_i));

  a_r6_snap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i && rd_addr_i == '0) |-> $stable(snap_q));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rd_data_o));
endmodule

// File: rtl/b1_err_counter.sv
`timescale 1ns/1ps
module b1_err_counter
  import b1_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned NUM_B  = CNT_W / BYTE_W,
  localparam int unsigned ADDR_W = (NUM_B > 1) ? $clog2(NUM_B) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [7:0]        data_i,
  input  logic              per_frame_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  b1_chk_t          chk;
  logic             add_vld, clr;
  logic [INC_W-1:0] add;
  logic [CNT_W-1:0] cnt;

  b1_bip8_calc u_bip8 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sof_i   (sof_i),
    .data_i  (data_i),
    .chk_o   (chk)
  );

  b1_err_weight u_weight (
    .chk_i       (chk),
    .per_frame_i (per_frame_i),
    .add_vld_o   (add_vld),
    .add_o       (add)
  );

  b1_err_accum #(.CNT_W(CNT_W)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .add_vld_i (add_vld),
    .add_i     (add),
    .clr_i     (clr),
    .cnt_o     (cnt)
  );

  b1_host_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (cnt),
    .clr_o     (clr),
    .rd_data_o (rd_data_o)
  );

  a_r4_frame_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(per_frame_i) && !$past(clr)) |-> (cnt - $past(cnt)) <= CNT_W'(1));

  a_r2_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sof_i, 2) && !$past(clr)) |-> $stable(cnt));
endmodule

// File: tb/b1_err_counter_tb.sv
`timescale 1ns/1ps
module b1_err_counter_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, valid, sof, mode, rd_a, rd_b, addr_b;
  logic [7:0] data, q_a, q_b;
  logic [1:0] addr_a;

  int     n_chk = 0, n_bad = 0;
  logic [7:0] par = '0;
  bit     have = 0;
  longint exp_a = 0, exp_b = 0;

  b1_err_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .data_i(data),
    .per_frame_i(mode), .rd_en_i(rd_a), .rd_addr_i(addr_a), .rd_data_o(q_a));

  b1_err_counter #(.CNT_W(16)) u_dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .data_i(data),
    .per_frame_i(mode), .rd_en_i(rd_b), .rd_addr_i(addr_b), .rd_data_o(q_b));

  function automatic longint sat(longint v, int w);
    longint m = (longint'(1) << w) - 1;
    return (v > m) ? m : v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit s, logic [7:0] d);
    valid = v; sof = s; data = d;
    @(negedge clk);
    valid = 1'b0; sof = 1'b0; rd_a = 1'b0; rd_b = 1'b0;
  endtask

  task automatic send_frame(logic [7:0] err, int seed);
    logic [7:0] b1, d1, d2;
    longint inc;
    b1 = have ? (par ^ err) : err;
    if (have) begin
      inc   = mode ? longint'(err != 0) : longint'($countones(err));
      exp_a = sat(exp_a + inc, 32);
      exp_b = sat(exp_b + inc, 16);
    end
    cyc(1, 1, b1);
    par = b1; have = 1;
    d1 = 8'(seed * 29 + 3); par ^= d1; cyc(1, 0, d1);
    cyc(0, 0, 8'hA5);                       // idle with garbage
    d2 = 8'(seed * 53 + 11); par ^= d2; cyc(1, 0, d2);
  endtask

  task automatic rd_byte_a(logic [1:0] k, output logic [7:0] b);
    rd_a = 1'b1; addr_a = k; cyc(0, 0, 8'h00); b = q_a;
  endtask

  task automatic read_all_a(string req);
    logic [7:0] b;
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      rd_byte_a(2'(k), b);
      w = {w[23:0], b};
    end
    check(req, longint'(w), exp_a);
    exp_a = 0;
  endtask

  task automatic read_b_bytes(string req);
    logic [7:0] hi, lo;
    rd_b = 1'b1; addr_b = 1'b0; cyc(0, 0, 8'h00); hi = q_b;
    rd_b = 1'b1; addr_b = 1'b1; cyc(0, 0, 8'h00); lo = q_b;
    check({req, " msb at addr0"}, longint'(hi), (exp_b >> 8) & 8'hFF);
    check({req, " lsb at addr1"}, longint'(lo), exp_b & 8'hFF);
    exp_b = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b, s1, s2, s3, s0;
    rst_n = 1'b0; valid = 0; sof = 0; data = '0; mode = 0;
    rd_a = 0; rd_b = 0; addr_a = '0; addr_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check("R9 rd_data after reset", longint'(q_a), 0);
    read_all_a("R9 count after reset");

    // R1: bytes before the first sof ignored; R2: first frame not compared
    cyc(1, 0, 8'h5A); cyc(1, 0, 8'hC3);
    send_frame(8'hFF, 1);
    send_frame(8'h00, 2);
    read_all_a("R2 first frame B1 not compared");

    // R3, R1: exhaustive per-bit sweep
    mode = 0;
    for (int e = 0; e < 256; e++) begin
      send_frame(8'(e), e + 7);
      if (e % 32 == 31) read_all_a("R3 per-bit sweep");
    end
    read_all_a("R6 clear on read");

    // R4: exhaustive per-frame sweep
    mode = 1;
    for (int e = 0; e < 256; e++) begin
      send_frame(8'(e), e + 300);
      if (e % 64 == 63) read_all_a("R4 per-frame sweep");
    end

    // R6/R7: increment on the same edge as the top-byte read
    mode = 0;
    for (int i = 0; i < 3; i++) send_frame(8'h0F, i + 900);
    check("R3 pre-snapshot model", exp_a, 12);
    b = par ^ 8'h07;
    cyc(1, 1, b); par = b;
    rd_a = 1'b1; addr_a = 2'd0; b = 8'h3C; par ^= b; cyc(1, 0, b);
    s0 = q_a;
    exp_a = 3; exp_b = sat(exp_b + 3, 16);
    send_frame(8'h01, 950);                 // arrives between snapshot reads
    rd_byte_a(2'd1, s1); rd_byte_a(2'd2, s2); rd_byte_a(2'd3, s3);
    check("R6 snapshot frozen across reads", longint'({s0, s1, s2, s3}), 12);
    read_all_a("R7 same-edge errors kept after clear");

    // R5: byte order on the 16-bit instance, then R8 saturation
    read_b_bytes("R5 clear narrow instance");
    for (int i = 0; i < 37; i++) send_frame(8'hFF, i);
    check("R5 model 0x0128", exp_b, 16'h0128);
    read_b_bytes("R5 byte order");
    read_all_a("R5 wide count");
    for (int i = 0; i < 8200; i++) send_frame(8'hFF, i);
    check("R8 model saturates", exp_b, 16'hFFFF);
    read_b_bytes("R8 saturation");
    read_all_a("R8 wide count unsaturated");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule